// File: doc/BRIEF.md
# Synchronous FIFO Bus Slave, Single Channel

This block sits on a synchronous parallel bus as the slave, clocked by the clock the slave itself supplies to the bus master. It carries one channel in each direction. The receive channel takes bytes from an internal packet side, packs them into 32-bit words and offers them to the master. The transmit channel takes 32-bit words, each with four byte enables, from the master and hands them to the packet side in order. Two active-low flags tell the master when it may act: one shows that transmit space is free, the other shows that receive data is waiting.

The master reads by holding output-enable low and pulling the read strobe low. It writes by pulling the write strobe low while output-enable is high. The data and byte-enable pins are split into in, out and drive-enable signals so that a pad ring can form the shared bidirectional pins. The slave drives them only while output-enable is low. On reads the slave supplies the byte enables. Every word carries all four enables except the final word of a transfer whose length is not a multiple of four. A write on a full transmit buffer and a read from an empty receive buffer each set a sticky error bit.

Top module: `sfp_slave`

## Requirements
- R1: After reset txs_n is 0, rxa_n is 1, ovf_err and udf_err are 0, dat_out and be_out are 0, rx_byte_rdy is 1 and tx_empty is 1.
- R2: txs_n is 0 while the transmit buffer has at least one free word slot, and it is 1 once the buffer holds DEPTH words, where DEPTH = 2*BANK_WORDS.
- R3: A clock edge with wr_n=0, oe_n=1 and txs_n=0 stores dat_in and be_in. Words leave on tx_pop_data and tx_pop_be in write order with their byte enables unchanged. wr_n=0 with oe_n=0 stores nothing.
- R4: A clock edge with wr_n=0, oe_n=1 and txs_n=1 stores nothing and sets ovf_err. ovf_err stays 1 until reset.
- R5: rxa_n is 0 while the receive buffer holds at least one word, and 1 when it is empty.
- R6: A clock edge with rd_n=0, oe_n=0 and rxa_n=0 removes the oldest receive word. Its data and enables appear on dat_out and be_out right after that edge. rxa_n goes to 1 on the same edge that removes the last word.
- R7: A clock edge with rd_n=0, oe_n=0 and rxa_n=1 leaves dat_out and be_out unchanged and sets udf_err. udf_err stays 1 until reset.
- R8: rd_n=0 while oe_n=1 removes nothing from the receive buffer.
- R9: dat_oe and be_oe are 1 exactly while oe_n is 0.
- R10: Receive packing is little-endian. Byte k (k=0..3) of each group of four accepted bytes goes to bits 8k+7:8k, and be bit k marks it valid.
- R11: A full word of four bytes carries be 4'hF. rx_flush with n pending bytes (n=1..3) closes a word with be = (1<<n)-1 and zero in the unused bytes. rx_flush with no pending bytes adds no word.
- R12: rx_byte_rdy is 0 while the receive buffer is full. A byte offered at that time is not taken.
- R13: Holding rd_n and oe_n low drains a full receive buffer of DEPTH words, one word per clock, in a single burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also sent to the master |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Master output-enable, active low |
| rd_n | input | 1 | Master read strobe, active low |
| wr_n | input | 1 | Master write strobe, active low |
| dat_in | input | 32 | Data from the master |
| be_in | input | 4 | Byte enables from the master |
| dat_out | output | 32 | Read data toward the master |
| be_out | output | 4 | Byte enables of the read word |
| dat_oe | output | 1 | Drive enable for the data pins |
| be_oe | output | 1 | Drive enable for the byte-enable pins |
| txs_n | output | 1 | Transmit space available, active low |
| rxa_n | output | 1 | Receive data available, active low |
| ovf_err | output | 1 | Sticky error: write on a full transmit buffer |
| udf_err | output | 1 | Sticky error: read from an empty receive buffer |
| rx_byte_vld | input | 1 | Packet side offers a receive byte |
| rx_byte | input | 8 | Receive byte from the packet side |
| rx_flush | input | 1 | Close the current partial receive word |
| rx_byte_rdy | output | 1 | Receive side can accept a byte or flush |
| tx_pop | input | 1 | Packet side takes the oldest transmit word |
| tx_pop_data | output | 32 | Oldest transmit word data |
| tx_pop_be | output | 4 | Oldest transmit word byte enables |
| tx_empty | output | 1 | Transmit buffer holds no word |

## Verification
The bench sweeps every byte count from one to nine through the receive packer. A wrong lane order or enable mask would show up as swapped bytes or stray enable bits on the final word. It fills both buffers to exactly DEPTH words and checks that the flag changes on the last slot, not one slot early or late. It then writes into the full transmit buffer and reads from the empty receive buffer. A design that stored the dropped word, or that changed dat_out on an empty read, fails the readback that follows. It also pulls the read strobe low with output-enable high and checks that no word goes missing, and it drains a full buffer with the strobe held low to catch read data that trails the flag by a cycle.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;
    localparam int LANE_W = $clog2(LANES);

    typedef struct packed {
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] data;
    } bus_word_t;

    // enable mask for the n lowest lanes
    function automatic logic [LANES-1:0] lane_mask(input logic [LANE_W:0] n);
        logic [LANES-1:0] m;
        m = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(n)) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/sfp_store.sv
module sfp_store
    import sfp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  bus_word_t push_word,
    input  logic      pop,
    output bus_word_t pop_word,
    output logic      full,
    output logic      empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    bus_word_t       mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;
    logic            do_push, do_pop;

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_word = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/sfp_rx_pack.sv
module sfp_rx_pack
    import sfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_dat,
    input  logic              flush,
    input  logic              full,
    output logic              byte_rdy,
    output logic              push,
    output bus_word_t         push_word
);
    logic [WORD_W-1:0] acc, acc_nxt;
    logic [LANE_W-1:0] lane;
    logic [LANE_W:0]   fill;
    logic              take, close;

    assign byte_rdy = !full;
    assign take     = byte_vld && !full;
    assign close    = flush && !full;

    always_comb begin
        acc_nxt = acc;
        if (take) acc_nxt[lane*BYTE_W +: BYTE_W] = byte_dat;
        fill = {1'b0, lane} + (LANE_W+1)'(take);
        push = (take && lane == LANE_W'(LANES - 1)) || (close && fill != '0);
        push_word.data = acc_nxt;
        push_word.be   = lane_mask(fill);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            lane <= '0;
        end else if (push) begin
            acc  <= '0;
            lane <= '0;
        end else if (take) begin
            acc  <= acc_nxt;
            lane <= lane + 1'b1;
        end
    end
endmodule

// File: rtl/sfp_bus_ctrl.sv
module sfp_bus_ctrl
    import sfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              oe_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [WORD_W-1:0] dat_in,
    input  logic [LANES-1:0]  be_in,
    input  logic              tx_full,
    input  logic              rx_empty,
    input  bus_word_t         rx_word,
    output logic              tx_push,
    output bus_word_t         tx_word,
    output logic              rx_pop,
    output logic [WORD_W-1:0] dat_out,
    output logic [LANES-1:0]  be_out,
    output logic              dat_oe,
    output logic              be_oe,
    output logic              txs_n,
    output logic              rxa_n,
    output logic              ovf_err,
    output logic              udf_err
);
    logic wr_req, rd_req;

    assign wr_req  = !wr_n && oe_n;
    assign rd_req  = !rd_n && !oe_n;
    assign tx_push = wr_req && !tx_full;
    assign rx_pop  = rd_req && !rx_empty;
    assign tx_word = '{be: be_in, data: dat_in};
    assign txs_n   = tx_full;
    assign rxa_n   = rx_empty;
    assign dat_oe  = !oe_n;
    assign be_oe   = !oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_out <= '0;
            be_out  <= '0;
            ovf_err <= 1'b0;
            udf_err <= 1'b0;
        end else begin
            if (rx_pop) begin
                dat_out <= rx_word.data;
                be_out  <= rx_word.be;
            end
            if (wr_req && tx_full)   ovf_err <= 1'b1;
            if (rd_req && rx_empty)  udf_err <= 1'b1;
        end
    end
endmodule

// File: rtl/sfp_slave.sv
module sfp_slave
    import sfp_pkg::*;
#(
    parameter int BANK_WORDS = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              oe_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [WORD_W-1:0] dat_in,
    input  logic [LANES-1:0]  be_in,
    output logic [WORD_W-1:0] dat_out,
    output logic [LANES-1:0]  be_out,
    output logic              dat_oe,
    output logic              be_oe,
    output logic              txs_n,
    output logic              rxa_n,
    output logic              ovf_err,
    output logic              udf_err,
    input  logic              rx_byte_vld,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_flush,
    output logic              rx_byte_rdy,
    input  logic              tx_pop,
    output logic [WORD_W-1:0] tx_pop_data,
    output logic [LANES-1:0]  tx_pop_be,
    output logic              tx_empty
);
    localparam int DEPTH = 2 * BANK_WORDS;

    bus_word_t rx_in_word, rx_out_word, tx_in_word, tx_out_word;
    logic      rx_push, rx_pop, rx_full, rx_empty;
    logic      tx_push, tx_full;

    sfp_rx_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .byte_vld  (rx_byte_vld),
        .byte_dat  (rx_byte),
        .flush     (rx_flush),
        .full      (rx_full),
        .byte_rdy  (rx_byte_rdy),
        .push      (rx_push),
        .push_word (rx_in_word)
    );

    sfp_store #(.DEPTH(DEPTH)) u_rx_store (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_push),
        .push_word (rx_in_word),
        .pop       (rx_pop),
        .pop_word  (rx_out_word),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    sfp_store #(.DEPTH(DEPTH)) u_tx_store (
        .clk       (clk),
        .rst       (rst),
        .push      (tx_push),
        .push_word (tx_in_word),
        .pop       (tx_pop),
        .pop_word  (tx_out_word),
        .full      (tx_full),
        .empty     (tx_empty)
    );

    sfp_bus_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .oe_n     (oe_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .dat_in   (dat_in),
        .be_in    (be_in),
        .tx_full  (tx_full),
        .rx_empty (rx_empty),
        .rx_word  (rx_out_word),
        .tx_push  (tx_push),
        .tx_word  (tx_in_word),
        .rx_pop   (rx_pop),
        .dat_out  (dat_out),
        .be_out   (be_out),
        .dat_oe   (dat_oe),
        .be_oe    (be_oe),
        .txs_n    (txs_n),
        .rxa_n    (rxa_n),
        .ovf_err  (ovf_err),
        .udf_err  (udf_err)
    );

    assign tx_pop_data = tx_out_word.data;
    assign tx_pop_be   = tx_out_word.be;
endmodule

// File: rtl/sfp_slave_chk.sv
module sfp_slave_chk (
    input logic        clk,
    input logic        rst,
    input logic        oe_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic [31:0] dat_out,
    input logic [3:0]  be_out,
    input logic        dat_oe,
    input logic        be_oe,
    input logic        txs_n,
    input logic        rxa_n,
    input logic        ovf_err,
    input logic        udf_err,
    input logic        tx_empty
);
    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err);

    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_n && oe_n && txs_n) |=> ovf_err);

    // R7
    udf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        udf_err |=> udf_err);

    // R7
    udf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !oe_n && rxa_n) |=> (udf_err && $stable(dat_out) && $stable(be_out)));

    // R2
    space_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> !txs_n);

    // R9
    drive_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (dat_oe != oe_n) && (be_oe == dat_oe));
endmodule

bind sfp_slave sfp_slave_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .oe_n     (oe_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .dat_out  (dat_out),
    .be_out   (be_out),
    .dat_oe   (dat_oe),
    .be_oe    (be_oe),
    .txs_n    (txs_n),
    .rxa_n    (rxa_n),
    .ovf_err  (ovf_err),
    .udf_err  (udf_err),
    .tx_empty (tx_empty)
);

// File: tb/sfp_slave_tb.sv
module sfp_slave_tb_top;
    localparam int BANK = 4;
    localparam int DEPTH = 2 * BANK;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        oe_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [31:0] dat_in = '0;
    logic [3:0]  be_in = '0;
    logic [31:0] dat_out;
    logic [3:0]  be_out;
    logic        dat_oe, be_oe, txs_n, rxa_n, ovf_err, udf_err;
    logic        rx_byte_vld = 1'b0, rx_flush = 1'b0, tx_pop = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_byte_rdy, tx_empty;
    logic [31:0] tx_pop_data;
    logic [3:0]  tx_pop_be;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sfp_slave #(.BANK_WORDS(BANK)) dut_i (
        .clk(clk), .rst(rst), .oe_n(oe_n), .rd_n(rd_n), .wr_n(wr_n),
        .dat_in(dat_in), .be_in(be_in), .dat_out(dat_out), .be_out(be_out),
        .dat_oe(dat_oe), .be_oe(be_oe), .txs_n(txs_n), .rxa_n(rxa_n),
        .ovf_err(ovf_err), .udf_err(udf_err), .rx_byte_vld(rx_byte_vld),
        .rx_byte(rx_byte), .rx_flush(rx_flush), .rx_byte_rdy(rx_byte_rdy),
        .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .tx_pop_be(tx_pop_be),
        .tx_empty(tx_empty)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [31:0] wdata(input int i);
        return 32'h5A00_0000 ^ (32'(i) * 32'h0103_0507);
    endfunction

    function automatic logic [7:0] rbyte(input int n, input int b);
        return 8'(n * 16 + b + 1);
    endfunction

    task automatic push_bytes(input int n, input int cnt, input bit fl);
        for (int b = 0; b < cnt; b++) begin
            rx_byte_vld = 1'b1;
            rx_byte = rbyte(n, b);
            tick();
        end
        rx_byte_vld = 1'b0;
        if (fl) begin
            rx_flush = 1'b1;
            tick();
            rx_flush = 1'b0;
        end
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1", {30'd0, txs_n, rxa_n, ovf_err, udf_err, rx_byte_rdy, tx_empty}, 36'b0_1_0_0_1_1);
        chk("R1", {be_out, dat_out}, 36'd0);
        chk("R9", {34'd0, dat_oe, be_oe}, 36'd0);

        // R3 write with oe_n low is not stored
        oe_n = 1'b0; wr_n = 1'b0; dat_in = 32'hDEAD_BEEF; be_in = 4'hF;
        tick();
        chk("R9", {34'd0, dat_oe, be_oe}, 36'b11);
        wr_n = 1'b1; oe_n = 1'b1;
        chk("R3", {35'd0, tx_empty}, 36'd1);

        // R2/R3 fill transmit buffer, sweeping all 16 enable codes over two rounds
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < DEPTH; i++) begin
                wr_n = 1'b0; dat_in = wdata(r * DEPTH + i); be_in = 4'(r * DEPTH + i);
                chk("R2", {35'd0, txs_n}, 36'd0);
                tick();
            end
            wr_n = 1'b1;
            chk("R2", {35'd0, txs_n}, 36'd1);
            if (r == 0) begin
                chk("R4", {35'd0, ovf_err}, 36'd0);
                // R4 write into full buffer
                wr_n = 1'b0; dat_in = 32'hBAD0_BAD0; be_in = 4'h5;
                tick();
                wr_n = 1'b1;
                chk("R4", {35'd0, ovf_err}, 36'd1);
            end
            for (int i = 0; i < DEPTH; i++) begin
                chk("R3", {tx_pop_be, tx_pop_data}, {4'(r * DEPTH + i), wdata(r * DEPTH + i)});
                tx_pop = 1'b1;
                tick();
                tx_pop = 1'b0;
            end
            chk("R3", {35'd0, tx_empty}, 36'd1);
        end
        chk("R4", {35'd0, ovf_err}, 36'd1);

        // R10/R11 sweep byte counts 1..9 through the packer
        for (int n = 1; n <= 9; n++) begin
            push_bytes(n, n, 1'b1);
            chk("R5", {35'd0, rxa_n}, 36'd0);
            oe_n = 1'b0; rd_n = 1'b0;
            for (int w = 0; w < (n + 3) / 4; w++) begin
                logic [31:0] ed;
                logic [3:0]  eb;
                int left;
                tick();
                left = n - 4 * w;
                ed = '0; eb = '0;
                for (int k = 0; k < 4; k++) begin
                    if (k < left) begin
                        ed[8*k +: 8] = rbyte(n, 4 * w + k);
                        eb[k] = 1'b1;
                    end
                end
                chk("R10", {be_out, dat_out}, {eb, ed});
                if (left < 4) chk("R11", {32'd0, be_out}, {32'd0, eb});
            end
            rd_n = 1'b1; oe_n = 1'b1;
            chk("R6", {35'd0, rxa_n}, 36'd1);
        end

        // R11 flush with nothing pending adds no word
        rx_flush = 1'b1; tick(); rx_flush = 1'b0;
        chk("R11", {35'd0, rxa_n}, 36'd1);

        // R7 underflow keeps output
        chk("R7", {35'd0, udf_err}, 36'd0);
        oe_n = 1'b0; rd_n = 1'b0;
        tick();
        rd_n = 1'b1; oe_n = 1'b1;
        chk("R7", {35'd0, udf_err}, 36'd1);
        chk("R7", {be_out, dat_out}, {4'b0001, 24'd0, rbyte(9, 8)});

        // R8 strobe with oe_n high removes nothing
        push_bytes(20, 4, 1'b0);
        rd_n = 1'b0; tick(); rd_n = 1'b1;
        chk("R8", {35'd0, rxa_n}, 36'd0);
        chk("R9", {34'd0, dat_oe, be_oe}, 36'd0);
        oe_n = 1'b0; rd_n = 1'b0; tick(); rd_n = 1'b1; oe_n = 1'b1;
        chk("R8", {be_out, dat_out}, {4'hF, rbyte(20, 3), rbyte(20, 2), rbyte(20, 1), rbyte(20, 0)});
        chk("R6", {35'd0, rxa_n}, 36'd1);

        // R12/R13 fill receive buffer, extra byte refused, burst drain
        push_bytes(30, 4 * DEPTH, 1'b0);
        chk("R12", {35'd0, rx_byte_rdy}, 36'd0);
        rx_byte_vld = 1'b1; rx_byte = 8'hEE; rx_flush = 1'b1;
        tick();
        rx_byte_vld = 1'b0; rx_flush = 1'b0;
        oe_n = 1'b0; rd_n = 1'b0;
        for (int w = 0; w < DEPTH; w++) begin
            chk("R13", {35'd0, rxa_n}, 36'd0);
            tick();
            chk("R13", {be_out, dat_out}, {4'hF, rbyte(30, 4*w+3), rbyte(30, 4*w+2),
                                          rbyte(30, 4*w+1), rbyte(30, 4*w)});
            if (w == 0) chk("R12", {35'd0, rx_byte_rdy}, 36'd1);
        end
        rd_n = 1'b1; oe_n = 1'b1;
        chk("R12", {35'd0, rxa_n}, 36'd1);

        done = 1'b1;
        finish_up();
    end
endmodule